// File: doc/BRIEF.md
# Dual-Supply Reset Sequencer

This block makes one system reset from four sources. Two of them are supply-good flags, one for each monitored rail. These arrive as comparator outputs that are already digital. The third is a manual reset that is low when active and comes from a push button. The fourth is a reset request from an external watchdog. While any source is active the reset stays asserted. After the last source goes away, the reset stays asserted for a further `HOLD_CYCLES` clocks and then releases.

Each rail flag passes through a filter before it counts as a source. A rail is treated as bad only when its flag has read low for `GLITCH_CYCLES` clocks in a row, so short dips do nothing. The manual reset is asynchronous and goes through a two-flop synchronizer. The watchdog request is synchronous and takes effect directly.

Both output polarities are driven from a single state register, so they can never disagree. The clock rate is folded into the two count parameters.

Top module: `supply_reset_seq`

## Requirements
- R1: While a filtered rail is bad, the watchdog request is high, or the synchronized manual reset is low, `rst_hi` is 1 on the next clock.
- R2: `rst_hi` falls exactly `HOLD_CYCLES` clocks after the first clock on which no source is active.
- R3: A low level on `mrst_n` asserts `rst_hi` on the third rising edge after it is first sampled, whatever the rail flags show. The extra edges are the synchronizer stages.
- R4: If any source comes back while the hold count is running, the count restarts from zero.
- R5: A rail that drops after release (flag `rail_ok[i]` = 0, bit i for rail i) makes reset assert again once the drop has lasted `GLITCH_CYCLES` clocks.
- R6: `rst_lo_n` is always the complement of `rst_hi`.
- R7: A low excursion on a rail flag that lasts fewer than `GLITCH_CYCLES` consecutive clocks has no effect on the outputs.
- R8: A watchdog request asserts `rst_hi` on the next clock. The hold count runs once the request clears.
- R9: While `rst` is high, the outputs show reset asserted. After `rst` falls, the hold count starts only once every source is absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rail_ok | input | NUM_RAILS | Per-rail supply-good flag, 1 = above threshold |
| mrst_n | input | 1 | Manual reset, active low, asynchronous |
| wd_req | input | 1 | Watchdog reset request, active high |
| rst_hi | output | 1 | System reset, active high |
| rst_lo_n | output | 1 | System reset, active low |

## Verification
The bench drives a rail dip one clock shorter than the filter length. A filter that is off by one would assert reset on that dip. It then checks the exact release clock after a watchdog pulse, which catches a hold counter that ends one clock early or late. A second request arrives midway through the hold, so a timer that does not restart would release too soon. Manual reset latency is compared cycle by cycle, which exposes a missing or extra synchronizer stage.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    typedef enum logic [1:0] {
        TMR_HELD     = 2'd0,
        TMR_COUNTING = 2'd1,
        TMR_RELEASED = 2'd2
    } tmr_state_e;

    typedef struct packed {
        logic mr_active;
        logic wd_active;
        logic rail_bad;
    } cause_t;

    function automatic logic any_cause(input cause_t c);
        return c.mr_active | c.wd_active | c.rail_bad;
    endfunction

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rsq_glitch_filter.sv
module rsq_glitch_filter
    import rsq_pkg::*;
#(
    parameter int GLITCH_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ok,
    output logic bad
);
    localparam int CW = cnt_width(GLITCH_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(GLITCH_CYCLES - 1);

    logic [CW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run <= '0;
            bad     <= 1'b1;
        end else if (ok) begin
            low_run <= '0;
            bad     <= 1'b0;
        end else if (low_run == LAST) begin
            bad     <= 1'b1;
        end else begin
            low_run <= low_run + 1'b1;
        end
    end
endmodule

// File: rtl/rsq_hold_timer.sv
module rsq_hold_timer
    import rsq_pkg::*;
#(
    parameter int HOLD_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic cause,
    output logic active
);
    localparam int CW = cnt_width(HOLD_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    tmr_state_e    state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TMR_HELD;
            cnt   <= '0;
        end else if (cause) begin
            state <= TMR_HELD;
            cnt   <= '0;
        end else begin
            case (state)
                TMR_HELD, TMR_COUNTING: begin
                    if (cnt == LAST) begin
                        state <= TMR_RELEASED;
                        cnt   <= '0;
                    end else begin
                        state <= TMR_COUNTING;
                        cnt   <= cnt + 1'b1;
                    end
                end
                default: state <= TMR_RELEASED;
            endcase
        end
    end

    assign active = (state != TMR_RELEASED);
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
    import rsq_pkg::*;
#(
    parameter int NUM_RAILS     = 2,
    parameter int GLITCH_CYCLES = 4,
    parameter int HOLD_CYCLES   = 20,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_RAILS-1:0] rail_ok,
    input  logic                 mrst_n,
    input  logic                 wd_req,
    output logic                 rst_hi,
    output logic                 rst_lo_n
);
    logic [NUM_RAILS-1:0] rail_bad;
    logic                 mr_sync;
    cause_t               causes;
    logic                 any_active;
    logic                 active;

    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
        rsq_glitch_filter #(
            .GLITCH_CYCLES(GLITCH_CYCLES)
        ) u_filt (
            .clk(clk),
            .rst(rst),
            .ok (rail_ok[i]),
            .bad(rail_bad[i])
        );
    end

    rsq_sync #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b0)
    ) u_mr_sync (
        .clk(clk),
        .rst(rst),
        .d  (mrst_n),
        .q  (mr_sync)
    );

    always_comb begin
        causes.mr_active = ~mr_sync;
        causes.wd_active = wd_req;
        causes.rail_bad  = |rail_bad;
        any_active       = any_cause(causes);
    end

    rsq_hold_timer #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .cause (any_active),
        .active(active)
    );

    assign rst_hi   = active;
    assign rst_lo_n = ~active;
endmodule

// File: rtl/supply_reset_seq_chk.sv
module supply_reset_seq_chk #(
    parameter int HOLD_CYCLES = 20
) (
    input logic clk,
    input logic rst,
    input logic wd_req,
    input logic cause,
    input logic rst_hi,
    input logic rst_lo_n
);
    localparam int QW = $clog2(HOLD_CYCLES + 2);
    localparam logic [QW-1:0] QMAX = QW'(HOLD_CYCLES + 1);

    logic [QW-1:0] quiet;

    always_ff @(posedge clk) begin
        if (rst || cause) begin
            quiet <= '0;
        end else if (quiet != QMAX) begin
            quiet <= quiet + 1'b1;
        end
    end

    AST_POLARITY_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        rst_lo_n == !rst_hi); // R6

    AST_CAUSE_HOLDS_RESET: assert property (@(posedge clk) disable iff (rst)
        cause |=> rst_hi); // R1

    AST_WD_ASSERTS: assert property (@(posedge clk) disable iff (rst)
        wd_req |=> rst_hi); // R8

    AST_RELEASE_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_hi) |-> (quiet == QW'(HOLD_CYCLES))); // R2

    AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (rst_hi && cause) |=> rst_hi); // R4
endmodule

bind supply_reset_seq supply_reset_seq_chk #(
    .HOLD_CYCLES(HOLD_CYCLES)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wd_req  (wd_req),
    .cause   (any_active),
    .rst_hi  (rst_hi),
    .rst_lo_n(rst_lo_n)
);

// File: tb/supply_reset_seq_test.sv
module supply_reset_seq_test;
    localparam int G = 4;
    localparam int H = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] rail_ok = 2'b11;
    logic       mrst_n = 1'b1;
    logic       wd_req = 1'b0;
    logic       rst_hi;
    logic       rst_lo_n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    supply_reset_seq #(
        .NUM_RAILS(2), .GLITCH_CYCLES(G), .HOLD_CYCLES(H), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst(rst), .rail_ok(rail_ok), .mrst_n(mrst_n),
        .wd_req(wd_req), .rst_hi(rst_hi), .rst_lo_n(rst_lo_n)
    );

    // behavioural reference
    int   m_run [2];
    bit   m_bad [2];
    bit   m_mr_q[$];
    int   m_hold;
    bit   m_act;

    always @(posedge clk) begin
        bit cause;
        cause = m_bad[0] | m_bad[1] | wd_req | (m_mr_q[1] == 1'b0);
        if (rst) begin
            m_act = 1; m_hold = 0;
            for (int i = 0; i < 2; i++) begin m_run[i] = 0; m_bad[i] = 1; end
            m_mr_q = '{1'b0, 1'b0};
        end else begin
            if (cause) begin
                m_act = 1; m_hold = 0;
            end else if (m_act) begin
                m_hold++;
                if (m_hold == H) begin m_act = 0; m_hold = 0; end
            end
            for (int i = 0; i < 2; i++) begin
                if (rail_ok[i]) begin m_run[i] = 0; m_bad[i] = 0; end
                else if (m_run[i] >= G - 1) m_bad[i] = 1;
                else m_run[i]++;
            end
            m_mr_q.push_front(mrst_n);
            void'(m_mr_q.pop_back());
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (!done && cycles > 5000) begin
            chk(0, "watchdog R1", cycles, 5000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
        if (cycles > 1) begin
            chk(rst_hi == m_act, "R1 model", rst_hi, m_act);
            chk(rst_lo_n == !rst_hi, "R6", rst_lo_n, !rst_hi);
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int n;
        bit seen;
        m_mr_q = '{1'b0, 1'b0};
        wait_n(3);
        chk(rst_hi == 1, "R9 reset state", rst_hi, 1);
        rst = 0;
        wait_n(H);
        chk(rst_hi == 1, "R9 still holding", rst_hi, 1);
        wait_n(5);
        chk(rst_hi == 0, "R9 release after power-on", rst_hi, 0);

        // R8 and R2: watchdog pulse, exact release clock
        wd_req = 1; @(negedge clk);
        chk(rst_hi == 1, "R8 watchdog asserts", rst_hi, 1);
        wd_req = 0;
        n = 0;
        while (rst_hi && n < 100) begin @(negedge clk); n++; end
        chk(n == H, "R2 hold length", n, H);

        // R7: dip one clock short of the filter
        rail_ok[0] = 0; wait_n(G - 1); rail_ok[0] = 1;
        seen = 0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); seen |= rst_hi; end
        chk(seen == 0, "R7 short dip ignored", seen, 0);

        // R5: rail drop after release
        rail_ok[1] = 0; wait_n(G + 1);
        chk(rst_hi == 1, "R5 reassert on rail drop", rst_hi, 1);
        wait_n(5); rail_ok[1] = 1;
        wait_n(H + 2);
        chk(rst_hi == 0, "R5 release after rail recovers", rst_hi, 0);

        // R3: manual reset through synchronizer
        mrst_n = 0; wait_n(2);
        chk(rst_hi == 0, "R3 sync latency", rst_hi, 0);
        @(negedge clk);
        chk(rst_hi == 1, "R3 manual asserts", rst_hi, 1);
        wait_n(3); mrst_n = 1;
        wait_n(H + 1);
        chk(rst_hi == 1, "R3 full hold after release", rst_hi, 1);
        wait_n(2);
        chk(rst_hi == 0, "R3 released", rst_hi, 0);

        // R4: restart on a second request mid-hold
        wd_req = 1; @(negedge clk); wd_req = 0;
        wait_n(H / 2);
        wd_req = 1; @(negedge clk); wd_req = 0;
        wait_n(H - 1);
        chk(rst_hi == 1, "R4 restart", rst_hi, 1);
        @(negedge clk);
        chk(rst_hi == 0, "R4 release after restart", rst_hi, 0);

        // R1: both rails bad together
        rail_ok = 2'b00; wait_n(G + 2);
        chk(rst_hi == 1, "R1 both rails bad", rst_hi, 1);
        rail_ok = 2'b01; wait_n(H + 4);
        chk(rst_hi == 1, "R1 one rail still bad", rst_hi, 1);
        rail_ok = 2'b11; wait_n(H + 2);
        chk(rst_hi == 0, "R1 release", rst_hi, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule